// File: doc/BRIEF.md
# USB Full-Speed NRZI Line Transmitter

This block turns a stream of pre-expanded 2-bit symbols into the differential line states of a USB full-speed link. An upstream byte expander offers one symbol at a time on a valid/ready handshake. The block NRZI-encodes the data bits. It inserts a stuffed zero after every run of six ones. It drives D+ and D− as J, K or SE0, and controls an output-enable for the pad drivers.

One code in the symbol alphabet marks end of packet. When that code arrives, the block sends the SE0/J trailer on its own and then releases the bus, so the framing logic upstream never has to count line states. Every bit time is a fixed number of clock cycles, and a new symbol is taken only at the end of a bit. If the upstream side fails to supply a symbol in time, the block ends the packet itself and raises a flag.

Top module: `usb_fs_nrzi_tx`

## Requirements
- R1: After reset, `oe_o` is 0, `sym_ready_o` is 1, and both `bad_sym_o` and `underrun_o` are 0.
- R2: Symbol 2'b11 is a data 0 and inverts the line between J and K. Symbol 2'b01 is a data 1 and keeps the line where it is. The first bit of a packet is encoded relative to J.
- R3: Each data or stuffed bit holds its line state for exactly 4 clock cycles. While the bus is driven, `sym_ready_o` can be high only in the last of those 4 cycles.
- R4: After six data ones in a row, counted since the last transmitted zero, one extra bit time with an inverted line follows the sixth one. Every transmitted zero, stuffed or not, restarts the count.
- R5: Symbol 2'b00 produces 8 cycles of SE0 and then 4 cycles of J. In the following cycle `oe_o` is 0 and `sym_ready_o` is 1. The next packet again starts from J with an empty ones count.
- R6: `sym_ready_o` stays 0 throughout a stuffed bit, except its final cycle, and throughout the whole end-of-packet trailer.
- R7: Symbol 2'b10 is sent as a data 1, and `bad_sym_o` goes high for exactly one cycle for each such symbol.
- R8: If `sym_valid_i` is low at a bit boundary while the bus is driven, `underrun_o` pulses for one cycle and the same trailer as in R5 follows that bit.
- R9: J is `dp_o`=1/`dn_o`=0, K is `dp_o`=0/`dn_o`=1, and SE0 is both 0. Both lines are never 1 while `oe_o` is 1.
- R10: While idle, the block waits for a valid symbol for as long as it takes, without enabling the drivers or flagging an underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, 4 cycles per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_i | input | 2 | Symbol: 00 end of packet, 01 one, 11 zero, 10 illegal |
| sym_valid_i | input | 1 | Symbol offered |
| sym_ready_o | output | 1 | Symbol taken at this edge if valid |
| dp_o | output | 1 | D+ level |
| dn_o | output | 1 | D− level |
| oe_o | output | 1 | Pad driver enable |
| bad_sym_o | output | 1 | One-cycle pulse for a 10 symbol |
| underrun_o | output | 1 | One-cycle pulse when the packet is cut for lack of data |

## Verification
A stuffed bit can land on the same bit boundary as a starved input or an illegal symbol. The bench provokes the first case by sending six ones and then dropping valid. The stuffed toggle must still be sent in full before the underrun trailer begins. It provokes the second case by placing a 10 code as the sixth one, which must produce both the error pulse and the inserted toggle. Both cases are judged against a per-cycle trace built from the requirements. The trace holds line state, output-enable and ready, and the bench also counts the flag pulses.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_STUFF,
    ST_SE0,
    ST_EOPJ
  } tx_state_e;

  localparam logic [1:0] SYM_EOP  = 2'b00;
  localparam logic [1:0] SYM_ONE  = 2'b01;
  localparam logic [1:0] SYM_BAD  = 2'b10;
  localparam logic [1:0] SYM_ZERO = 2'b11;
endpackage

// File: rtl/usb_tx_bit_timer.sv
module usb_tx_bit_timer #(
  parameter int CYC_PER_BIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int W = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
  localparam logic [W-1:0] LAST = W'(CYC_PER_BIT - 1);

  logic [W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ph_q <= '0;
    else if (!run_i)         ph_q <= '0;
    else if (ph_q == LAST)   ph_q <= '0;
    else                     ph_q <= ph_q + W'(1);
  end

  assign last_o = run_i && (ph_q == LAST);

  AST_PHASE_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (ph_q == '0)); // R3
  AST_PHASE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= LAST); // R3
endmodule

// File: rtl/usb_tx_stuffer.sv
module usb_tx_stuffer #(
  parameter int STUFF_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic take_i,
  input  logic bit_one_i,
  input  logic stuff_i,
  output logic line_k_o,
  output logic stuff_due_o
);
  localparam int CW = $clog2(STUFF_LEN);
  localparam logic [CW-1:0] RELOAD = CW'(STUFF_LEN - 1);

  logic          line_k_q;
  logic [CW-1:0] cnt_q;
  logic          due_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_k_q <= 1'b0;
      cnt_q    <= RELOAD;
      due_q    <= 1'b0;
    end else if (clear_i) begin
      line_k_q <= 1'b0;
      cnt_q    <= RELOAD;
      due_q    <= 1'b0;
    end else if (stuff_i) begin
      line_k_q <= ~line_k_q;
      cnt_q    <= RELOAD;
      due_q    <= 1'b0;
    end else if (take_i) begin
      if (bit_one_i) begin
        if (cnt_q == '0) due_q <= 1'b1;
        else             cnt_q <= cnt_q - CW'(1);
      end else begin
        line_k_q <= ~line_k_q;
        cnt_q    <= RELOAD;
      end
    end
  end

  assign line_k_o    = line_k_q;
  assign stuff_due_o = due_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RELOAD); // R4
  AST_ZERO_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !bit_one_i && !clear_i && !stuff_i) |=> (cnt_q == RELOAD)); // R4
  AST_ONE_HOLDS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && bit_one_i && !clear_i && !stuff_i) |=> $stable(line_k_q)); // R2
  AST_ZERO_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !bit_one_i && !clear_i && !stuff_i) |=> (line_k_q != $past(line_k_q))); // R2
endmodule

// File: rtl/usb_fs_nrzi_tx.sv
module usb_fs_nrzi_tx
  import usb_tx_pkg::*;
#(
  parameter int CYC_PER_BIT  = 4,
  parameter int STUFF_LEN    = 6,
  parameter int EOP_SE0_BITS = 2,
  parameter int EOP_J_BITS   = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sym_i,
  input  logic       sym_valid_i,
  output logic       sym_ready_o,
  output logic       dp_o,
  output logic       dn_o,
  output logic       oe_o,
  output logic       bad_sym_o,
  output logic       underrun_o
);
  localparam int EOP_MAX = (EOP_SE0_BITS > EOP_J_BITS) ? EOP_SE0_BITS : EOP_J_BITS;
  localparam int EC_W    = $clog2(EOP_MAX + 1);
  localparam logic [EC_W-1:0] SE0_END = EC_W'(EOP_SE0_BITS - 1);
  localparam logic [EC_W-1:0] J_END   = EC_W'(EOP_J_BITS - 1);

  tx_state_e       state_q, state_d;
  logic [EC_W-1:0] eop_cnt_q, eop_cnt_d;
  logic            bad_q, und_q;

  logic bit_last, line_k, stuff_due;
  logic in_bit, boundary, take, is_eop, bit_take, stuff_go, underrun_go;

  usb_tx_bit_timer #(.CYC_PER_BIT(CYC_PER_BIT)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .last_o (bit_last)
  );

  usb_tx_stuffer #(.STUFF_LEN(STUFF_LEN)) u_stuff (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (state_q == ST_SE0),
    .take_i      (bit_take),
    .bit_one_i   (sym_i != SYM_ZERO),
    .stuff_i     (stuff_go),
    .line_k_o    (line_k),
    .stuff_due_o (stuff_due)
  );

  assign in_bit      = (state_q == ST_DATA) || (state_q == ST_STUFF);
  assign boundary    = (state_q == ST_IDLE) || (in_bit && bit_last);
  assign stuff_go    = (state_q == ST_DATA) && bit_last && stuff_due;
  assign sym_ready_o = boundary && !stuff_go;
  assign take        = sym_ready_o && sym_valid_i;
  assign is_eop      = (sym_i == SYM_EOP);
  assign bit_take    = take && !is_eop;
  assign underrun_go = sym_ready_o && !sym_valid_i && in_bit;

  always_comb begin
    state_d   = state_q;
    eop_cnt_d = eop_cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        eop_cnt_d = '0;
        if (take) state_d = is_eop ? ST_SE0 : ST_DATA;
      end
      ST_DATA, ST_STUFF: begin
        eop_cnt_d = '0;
        if (stuff_go)      state_d = ST_STUFF;
        else if (take)     state_d = is_eop ? ST_SE0 : ST_DATA;
        else if (boundary) state_d = ST_SE0;  // underrun
      end
      ST_SE0: if (bit_last) begin
        if (eop_cnt_q == SE0_END) begin
          state_d   = ST_EOPJ;
          eop_cnt_d = '0;
        end else begin
          eop_cnt_d = eop_cnt_q + EC_W'(1);
        end
      end
      ST_EOPJ: if (bit_last) begin
        if (eop_cnt_q == J_END) state_d = ST_IDLE;
        else                    eop_cnt_d = eop_cnt_q + EC_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      eop_cnt_q <= '0;
      bad_q     <= 1'b0;
      und_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      eop_cnt_q <= eop_cnt_d;
      bad_q     <= take && (sym_i == SYM_BAD);
      und_q     <= underrun_go;
    end
  end

  // line_k is cleared to J during SE0, so EOPJ and IDLE show J
  assign oe_o       = (state_q != ST_IDLE);
  assign dp_o       = (state_q != ST_SE0) && !line_k;
  assign dn_o       = (state_q != ST_SE0) && line_k;
  assign bad_sym_o  = bad_q;
  assign underrun_o = und_q;

  AST_PAIR_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> !(dp_o && dn_o)); // R9
  AST_NO_READY_IN_SE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !dp_o && !dn_o) |-> !sym_ready_o); // R6
  AST_UNDERRUN_STARTS_SE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> (oe_o && !dp_o && !dn_o)); // R8
  AST_UNDERRUN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !underrun_o); // R8
  AST_BAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_sym_o |=> !bad_sym_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (!underrun_o && sym_ready_o)); // R10
  AST_STUFF_HOLDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STUFF && !bit_last) |-> !sym_ready_o); // R6
endmodule

// File: tb/sim_usb_fs_nrzi_tx.sv
`timescale 1ns/1ps
module sim_usb_fs_nrzi_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sym = 2'b00;
  logic       valid = 1'b0;
  logic       rdy, dp, dn, oe, bad, und;

  always #2.5 clk = ~clk;

  usb_fs_nrzi_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .sym_i(sym), .sym_valid_i(valid),
    .sym_ready_o(rdy), .dp_o(dp), .dn_o(dn), .oe_o(oe),
    .bad_sym_o(bad), .underrun_o(und)
  );

  int vec_cnt = 0;
  int err_cnt = 0;

  logic [3:0] tr [0:4095];   // {oe, dp, dn, ready}
  logic [3:0] ex [0:4095];
  int  tr_n, ex_n, bad_hi, und_hi;
  logic cap = 1'b0;
  logic [1:0] pk [0:63];
  int  pk_n;

  always @(negedge clk) begin
    if (cap) begin
      if ((tr_n > 0 || oe) && tr_n < 4096) begin
        tr[tr_n] = {oe, dp, dn, rdy};
        tr_n++;
      end
      bad_hi += int'(bad);
      und_hi += int'(und);
    end
  end

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic push_bit(input logic k, input logic rl);
    for (int c = 0; c < 4; c++) begin
      ex[ex_n] = {1'b1, ~k, k, (c == 3) ? rl : 1'b0};
      ex_n++;
    end
  endtask

  // expected trace from R2 R3 R4 R5 R6 R9; a missing EOP behaves as one (R8)
  task automatic build_exp(output int n_bad);
    logic k = 1'b0;
    int   cnt = 5;
    n_bad = 0;
    ex_n = 0;
    for (int i = 0; i < pk_n; i++) begin
      if (pk[i] == 2'b00) break;
      if (pk[i] == 2'b11) begin
        k = ~k; cnt = 5; push_bit(k, 1'b1);
      end else begin
        if (pk[i] == 2'b10) n_bad++;
        if (cnt == 0) begin
          push_bit(k, 1'b0); k = ~k; push_bit(k, 1'b1); cnt = 5;
        end else begin
          cnt--; push_bit(k, 1'b1);
        end
      end
    end
    for (int c = 0; c < 8; c++) begin ex[ex_n] = 4'b1000; ex_n++; end
    for (int c = 0; c < 4; c++) begin ex[ex_n] = 4'b1100; ex_n++; end
  endtask

  task automatic send(input logic [1:0] s);
    logic r;
    @(negedge clk);
    sym = s; valid = 1'b1;
    forever begin
      #2; r = rdy;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
  endtask

  task automatic run_pkt(input logic has_eop);
    int nb, t;
    tr_n = 0; bad_hi = 0; und_hi = 0; cap = 1'b1;
    for (int i = 0; i < pk_n; i++) send(pk[i]);
    @(negedge clk); valid = 1'b0;
    t = 0;
    do begin
      @(negedge clk); #1; t++;
    end while (!(tr_n > 0 && tr[tr_n-1][3] == 1'b0) && t < 3000);
    cap = 1'b0;
    build_exp(nb);
    chk("R3 trace length", tr_n == ex_n + 1, tr_n, ex_n + 1);
    for (int i = 0; i < ex_n && i < tr_n; i++)
      chk("R2 R3 R4 R6 R9 line/ready", tr[i] == ex[i], tr[i], ex[i]);
    if (tr_n > 0)
      chk("R5 release to idle", tr[tr_n-1][3] == 1'b0 && tr[tr_n-1][0] == 1'b1,
          tr[tr_n-1], 4'b0001);
    chk("R7 bad symbol pulses", bad_hi == nb, bad_hi, nb);
    chk("R8 underrun pulses", und_hi == (has_eop ? 0 : 1), und_hi, has_eop ? 0 : 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog act hung exp done");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 oe after reset", oe == 1'b0, oe, 0);
    chk("R1 ready after reset", rdy == 1'b1, rdy, 1);
    chk("R1 flags after reset", {bad, und} == 2'b00, {bad, und}, 0);
    rst_n = 1'b1;

    // R10: long idle wait
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk("R10 idle wait", oe == 1'b0 && und == 1'b0 && rdy == 1'b1, {oe, und, rdy}, 3'b001);
    end

    // R5: bare EOP from idle
    pk_n = 1; pk[0] = 2'b00; run_pkt(1'b1);

    // R2: alternating zeros and ones
    pk_n = 9;
    for (int i = 0; i < 8; i++) pk[i] = i[0] ? 2'b01 : 2'b11;
    pk[8] = 2'b00; run_pkt(1'b1);

    // R4: thirteen ones -> two stuffed bits
    pk_n = 14;
    for (int i = 0; i < 13; i++) pk[i] = 2'b01;
    pk[13] = 2'b00; run_pkt(1'b1);

    // R4 R7: illegal code as the sixth one, stuff and flag together
    pk_n = 8; pk[0] = 2'b11;
    for (int i = 1; i < 6; i++) pk[i] = 2'b01;
    pk[6] = 2'b10; pk[7] = 2'b00; run_pkt(1'b1);

    // R8 R4: six ones then starve, stuff precedes the underrun trailer
    pk_n = 6;
    for (int i = 0; i < 6; i++) pk[i] = 2'b01;
    run_pkt(1'b0);

    // R8: starve after a zero
    pk_n = 3; pk[0] = 2'b11; pk[1] = 2'b01; pk[2] = 2'b11; run_pkt(1'b0);

    // random packets biased toward long runs of ones
    for (int p = 0; p < 40; p++) begin
      logic eop_end;
      int   len;
      len = 1 + int'($urandom % 40);
      eop_end = ($urandom % 5) != 0;
      for (int i = 0; i < len; i++) begin
        int r;
        r = int'($urandom % 16);
        pk[i] = (r < 4) ? 2'b11 : (r == 4) ? 2'b10 : 2'b01;
      end
      if (eop_end) begin pk[len] = 2'b00; pk_n = len + 1; end
      else pk_n = len;
      run_pkt(eop_end);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule